// File: doc/BRIEF.md
# Tamper Alarm Supervisor

This block watches four physical tamper lines and two supply-fault flags and drives an active-low alarm output. Every line is brought into the clock domain by a two-stage synchronizer. A per-line run-length filter then removes short glitches. Each filtered level is compared with that line's resting level. The over-voltage and under-voltage flags come from analog comparators outside the block, and any asserted flag counts as a fault in the same way as a tamper.

Alarm reporting is held off after a cold start. The main-power-good input must stay high for a full recovery window before the block arms. Once armed, it stays armed whether main power or battery is feeding the part, until the power-loss reset clears it. The alarm does not latch: it follows the fault conditions.

A switched supply output is modelled as an enable bit and a 2-bit drive mode. During an alarm, the drive mode is taken from a static variant select.

Top module: `tamper_supervisor`

## Requirements
- R1: Lines 0 and 2 of `tamper_in` rest high and signal a tamper when low. Lines 1 and 3 rest low and signal a tamper when high. When the block is armed, a tamper on any one line, or on any combination of lines, drives `alarm_n` low.
- R2: When the block is armed, a high level on `over_volt` or `under_volt` drives `alarm_n` low on the third rising clock edge after the flag changes. Clearing the flag releases the alarm with the same latency.
- R3: The alarm does not latch. `alarm_n` goes back high as soon as no tamper and no supply fault remains.
- R4: A change on a tamper line counts only after its synchronized value has differed from the filtered level for FILT_LEN consecutive clocks. `alarm_n` then reacts on the (FILT_LEN+3)-th rising edge after the line changes. A pulse of FILT_LEN-1 clocks has no effect.
- R5: While the block is not armed, `alarm_n` stays high, `vout_en` stays 1 and `vout_mode` stays 00, whatever the tamper and fault inputs do.
- R6: The block arms when `main_pwr_ok` has been high for REC_CYCLES consecutive synchronized clocks. A drop before that point restarts the count. The first alarm can appear on the (REC_CYCLES+3)-th rising edge after `main_pwr_ok` rises.
- R7: Once armed, the block stays armed when `main_pwr_ok` falls (battery operation). Only `rst_n` low disarms it.
- R8: With no alarm, `vout_mode` is 00 (driven on) and `vout_en` is 1. During an alarm, `variant` 00 gives mode 00 with enable 1, 01 gives mode 01 (high impedance) with enable 0, and 10 or 11 gives mode 10 (ground) with enable 1. The outputs change in the same cycle as `alarm_n`.
- R9: In reset, and right after it, `alarm_n` is 1, `vout_en` is 1 and `vout_mode` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-loss reset, released synchronously inside the block |
| tamper_in | input | 4 | Raw tamper lines with mixed resting levels |
| over_volt | input | 1 | Internal supply above the high trip point |
| under_volt | input | 1 | Internal supply below the low trip point |
| main_pwr_ok | input | 1 | Main power above its reset threshold |
| variant | input | 2 | Selects the output drive mode during an alarm |
| alarm_n | output | 1 | Active-low security alarm |
| vout_en | output | 1 | Switched output is actively driven |
| vout_mode | output | 2 | Switched output drive mode: 00 on, 01 high impedance, 10 ground |

## Verification
The path through the filter is FILT_LEN clocks longer than the path through the supply-flag synchronizer. This lets a tamper onset and the clearing of a supply fault take effect inside the block on the same clock edge. The bench provokes this by raising a tamper line while over-voltage is asserted, then dropping over-voltage exactly FILT_LEN clocks later. It samples `alarm_n` on every cycle across the handover and expects it to stay low without a single high cycle. After that, clearing the tamper alone must release the alarm.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  typedef enum logic [1:0] {
    DRV_ON  = 2'b00,
    DRV_HIZ = 2'b01,
    DRV_GND = 2'b10
  } drv_mode_e;

  function automatic drv_mode_e variant_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   return DRV_ON;
      2'b01:   return DRV_HIZ;
      default: return DRV_GND;
    endcase
  endfunction
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {2{RST_VAL}};
    else        stg_q <= {stg_q[0], d};
  end

  assign q = stg_q[1];
endmodule

// File: rtl/tamper_filter.sv
module tamper_filter #(
  parameter int   FILT_LEN = 4,
  parameter logic IDLE     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

  logic             smp;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  tamper_sync #(.RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(smp)
  );

  always_comb begin
    cnt_d = '0;
    lvl_d = lvl_q;
    if (smp != lvl_q) begin
      if (cnt_q == LAST) lvl_d = smp;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= IDLE;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  // R4: the filtered level can only move to a value the synchronizer has shown
  a_r4_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(smp) == lvl_q));
endmodule

// File: rtl/arm_ctrl.sv
module arm_ctrl #(
  parameter int REC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_raw,
  output logic armed
);
  localparam int CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

  logic             pwr_s;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  tamper_sync #(.RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pwr_raw), .q(pwr_s)
  );

  always_comb begin
    cnt_d   = '0;
    armed_d = armed_q;
    if (!armed_q && pwr_s) begin
      if (cnt_q == LAST) armed_d = 1'b1;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  // R7: once armed, stays armed until reset
  a_r7_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R6: arming happens only while main power is seen as good
  a_r6_arm_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(pwr_s));
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor
  import tamper_pkg::*;
#(
  parameter int FILT_LEN   = 4,
  parameter int REC_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tamper_in,
  input  logic       over_volt,
  input  logic       under_volt,
  input  logic       main_pwr_ok,
  input  logic [1:0] variant,
  output logic       alarm_n,
  output logic       vout_en,
  output logic [1:0] vout_mode
);
  localparam int         N_LINES  = 4;
  localparam logic [3:0] IDLE_LVL = 4'b0101;

  logic [1:0]         rst_sq;
  logic               rst_core_n;
  logic [N_LINES-1:0] lvl;
  logic               ov_s, uv_s, armed, fault;
  logic               alarm_d, alarm_q;
  drv_mode_e          mode_d, mode_q;
  logic               en_d, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_core_n = rst_sq[1];

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    tamper_filter #(.FILT_LEN(FILT_LEN), .IDLE(IDLE_LVL[i])) u_filt (
      .clk(clk), .rst_n(rst_core_n), .raw(tamper_in[i]), .lvl(lvl[i])
    );
  end

  tamper_sync #(.RST_VAL(1'b0)) u_ov (
    .clk(clk), .rst_n(rst_core_n), .d(over_volt), .q(ov_s)
  );
  tamper_sync #(.RST_VAL(1'b0)) u_uv (
    .clk(clk), .rst_n(rst_core_n), .d(under_volt), .q(uv_s)
  );

  arm_ctrl #(.REC_CYCLES(REC_CYCLES)) u_arm (
    .clk(clk), .rst_n(rst_core_n), .pwr_raw(main_pwr_ok), .armed(armed)
  );

  always_comb begin
    fault   = (|(lvl ^ IDLE_LVL)) | ov_s | uv_s;
    alarm_d = armed & fault;
    mode_d  = alarm_d ? variant_mode(variant) : DRV_ON;
    en_d    = (mode_d != DRV_HIZ);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      alarm_q <= 1'b0;
      mode_q  <= DRV_ON;
      en_q    <= 1'b1;
    end else begin
      alarm_q <= alarm_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
    end
  end

  assign alarm_n   = ~alarm_q;
  assign vout_en   = en_q;
  assign vout_mode = mode_q;

  // R5: no alarm is reported while disarmed
  a_r5_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_core_n)
    !armed |=> alarm_n);
  // R3: with no condition present the alarm releases
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_core_n)
    !fault |=> alarm_n);
  // R8: high impedance never coexists with the enable
  a_r8_hiz_disabled: assert property (@(posedge clk) disable iff (!rst_core_n)
    (vout_mode == DRV_HIZ) |-> !vout_en);
  // R8: outside an alarm the output is driven on
  a_r8_normal_on: assert property (@(posedge clk) disable iff (!rst_core_n)
    alarm_n |-> (vout_mode == DRV_ON && vout_en));
endmodule

// File: tb/tamper_supervisor_test.sv
module tamper_supervisor_test;
  localparam int         FL   = 4;
  localparam int         RC   = 16;
  localparam logic [3:0] IDLE = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tamper_in;
  logic       over_volt, under_volt, main_pwr_ok;
  logic [1:0] variant;
  logic       alarm_n, vout_en;
  logic [1:0] vout_mode;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  tamper_supervisor #(.FILT_LEN(FL), .REC_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .tamper_in(tamper_in), .over_volt(over_volt),
    .under_volt(under_volt), .main_pwr_ok(main_pwr_ok), .variant(variant),
    .alarm_n(alarm_n), .vout_en(vout_en), .vout_mode(vout_mode)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    check("R9", "alarm_n after reset", alarm_n, 1);
    check("R9", "vout_en after reset", vout_en, 1);
    check("R9", "vout_mode after reset", vout_mode, 0);
  endtask

  task automatic t_unarmed_and_arming;
    tamper_in[0] = 1'b0;
    step(FL + 10);
    check("R5", "alarm_n disarmed with tamper", alarm_n, 1);
    check("R5", "vout_mode disarmed", vout_mode, 0);
    main_pwr_ok = 1'b1;
    step(RC / 2);
    main_pwr_ok = 1'b0;
    step(5);
    main_pwr_ok = 1'b1;
    step(RC + 2);
    check("R6", "alarm_n one cycle before arming (count restarted)", alarm_n, 1);
    step(1);
    check("R6", "alarm_n at arming edge", alarm_n, 0);
  endtask

  task automatic t_battery;
    main_pwr_ok = 1'b0;
    step(10);
    check("R7", "alarm_n on battery", alarm_n, 0);
    tamper_in[0] = 1'b1;
    step(FL + 2);
    check("R4", "alarm_n before filter latency", alarm_n, 0);
    step(1);
    check("R3", "alarm_n released after clear", alarm_n, 1);
  endtask

  task automatic t_polarity;
    for (int i = 0; i < 4; i++) begin
      tamper_in = IDLE ^ (4'b1 << i);
      step(FL + 3);
      check("R1", $sformatf("alarm_n line %0d tamper", i), alarm_n, 0);
      tamper_in = IDLE;
      step(FL + 3);
      check("R3", $sformatf("alarm_n line %0d clear", i), alarm_n, 1);
    end
    tamper_in = 4'b1010;
    step(FL + 3);
    check("R1", "alarm_n all lines tampered", alarm_n, 0);
    tamper_in = IDLE;
    step(FL + 3);
  endtask

  task automatic t_glitch;
    int low_seen = 0;
    tamper_in[1] = 1'b1;
    step(FL - 1);
    tamper_in[1] = 1'b0;
    for (int k = 0; k < FL + 6; k++) begin
      step(1);
      if (!alarm_n) low_seen++;
    end
    check("R4", "short pulse rejected (low cycles)", low_seen, 0);
    tamper_in[1] = 1'b1;
    step(FL);
    tamper_in[1] = 1'b0;
    step(2);
    check("R4", "full pulse not yet seen", alarm_n, 1);
    step(1);
    check("R4", "full pulse accepted", alarm_n, 0);
    step(FL + 4);
    check("R3", "release after pulse", alarm_n, 1);
  endtask

  task automatic t_supply;
    over_volt = 1'b1;
    step(2);
    check("R2", "over_volt before latency", alarm_n, 1);
    step(1);
    check("R2", "over_volt alarm", alarm_n, 0);
    over_volt = 1'b0;
    step(3);
    check("R3", "over_volt release", alarm_n, 1);
    under_volt = 1'b1;
    step(3);
    check("R2", "under_volt alarm", alarm_n, 0);
    under_volt = 1'b0;
    step(3);
    check("R3", "under_volt release", alarm_n, 1);
  endtask

  task automatic t_variant;
    logic [1:0] em;
    for (int v = 0; v < 4; v++) begin
      variant = 2'(v);
      em = (v == 0) ? 2'b00 : (v == 1) ? 2'b01 : 2'b10;
      step(2);
      check("R8", $sformatf("variant %0d idle mode", v), vout_mode, 0);
      over_volt = 1'b1;
      step(3);
      check("R8", $sformatf("variant %0d alarm mode", v), vout_mode, em);
      check("R8", $sformatf("variant %0d alarm enable", v), vout_en, (v == 1) ? 0 : 1);
      over_volt = 1'b0;
      step(3);
      check("R8", $sformatf("variant %0d back on", v), {vout_en, vout_mode}, 3'b100);
    end
    variant = 2'b00;
  endtask

  task automatic t_overlap;
    int high_seen = 0;
    over_volt = 1'b1;
    step(3);
    tamper_in[3] = 1'b1;
    step(FL);
    over_volt = 1'b0;
    for (int k = 0; k < 10; k++) begin
      step(1);
      if (alarm_n) high_seen++;
    end
    check("R3", "no release across fault handover", high_seen, 0);
    tamper_in[3] = 1'b0;
    step(FL + 3);
    check("R3", "release after last condition clears", alarm_n, 1);
  endtask

  task automatic t_rearm;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(4);
    check("R9", "alarm_n after second reset", alarm_n, 1);
    over_volt = 1'b1;
    step(6);
    check("R7", "reset disarmed the block", alarm_n, 1);
    over_volt = 1'b0;
    step(3);
  endtask

  initial begin
    rst_n = 1'b0; tamper_in = IDLE; over_volt = 1'b0; under_volt = 1'b0;
    main_pwr_ok = 1'b0; variant = 2'b00;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_unarmed_and_arming();
    t_battery();
    t_polarity();
    t_glitch();
    t_supply();
    t_variant();
    t_overlap();
    t_rearm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule